// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block keeps a single-rank SDR SDRAM refreshed. A programmable interval counter raises one refresh request each time the interval expires. Requests wait in a small pending count until the block can get the command bus. Each request is served by one refresh sequence. The block raises a bus request and waits for a grant. It then closes every bank with a precharge-all. After the precharge recovery time it issues AUTO REFRESH, and it keeps the bus quiet with NOP until the refresh cycle time has elapsed.

Two modes are offered. In distributed mode each request produces exactly one AUTO REFRESH, which spreads the refreshes evenly over the retention period. In burst mode each request produces a configurable number of AUTO REFRESH commands back to back, one every refresh cycle time, after a single precharge-all. Mode and burst length are captured when the grant is taken, so changing them in the middle of a sequence has no effect on it. When the grant is held back for long enough that the pending count would go past its limit, a sticky overflow flag records that a refresh was lost.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, the pins read command inhibit (csN=1, rasN=1, casN=1, weN=1), a10=0, and busy, busReq and overflow are 0.
- R2: A request is raised every refreshInterval cycles. The first one comes refreshInterval cycles after the counter leaves zero, and the counter restarts whenever it reaches or passes refreshInterval-1. A refreshInterval of 0 stops requests and holds the counter at zero.
- R3: busReq and busy are high from the cycle after the block sees a pending request until its sequence ends. Only command inhibit is driven while busy is low or the grant is still awaited. A grant that is sampled high while busReq is high makes the precharge-all appear in the next cycle.
- R4: Precharge-all is driven for one cycle as csN=0, rasN=0, casN=1, weN=0 with a10=1.
- R5: AUTO REFRESH is driven for one cycle as csN=0, rasN=0, casN=0, weN=1 with a10=0. The first one of a sequence comes exactly T_RP cycles after the precharge-all.
- R6: Every cycle of a sequence that is not a precharge-all or an AUTO REFRESH drives NOP (csN=0, rasN=1, casN=1, weN=1, a10=0). The bus is released (busy=0) exactly T_RFC cycles after the last AUTO REFRESH.
- R7: In distributed mode (burstMode=0) each sequence issues exactly one AUTO REFRESH.
- R8: In burst mode (burstMode=1) each sequence issues burstLen AUTO REFRESH commands, or one when burstLen is 0, spaced exactly T_RFC cycles apart.
- R9: Up to MAX_PENDING requests are held while the grant is withheld, and each of them is later served by its own sequence.
- R10: A request that arrives while MAX_PENDING are pending and none is taken in that cycle sets overflow. Once set, overflow stays set until reset.
- R11: burstMode and burstLen are sampled when the grant is taken. Changes made during a sequence do not alter the number of AUTO REFRESH commands it issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refreshInterval | input | IVL_W | Cycles between refresh requests, 0 stops them |
| burstMode | input | 1 | 0 distributed, 1 burst |
| burstLen | input | LEN_W | AUTO REFRESH commands per burst sequence (0 means 1) |
| busGrant | input | 1 | Command bus granted to this block |
| busReq | output | 1 | Command bus requested |
| busy | output | 1 | Sequence in progress, block owns or awaits the bus |
| csN | output | 1 | SDRAM chip select, active low |
| rasN | output | 1 | SDRAM row strobe, active low |
| casN | output | 1 | SDRAM column strobe, active low |
| weN | output | 1 | SDRAM write enable, active low |
| a10 | output | 1 | SDRAM address bit 10, all-bank select on precharge |
| overflow | output | 1 | Sticky flag: a refresh request was lost |

## Verification
The bench builds the block with T_RP=3, T_RFC=5, MAX_PENDING=3, an 8-bit interval and a 3-bit burst length. These short timings let a full burst of three refreshes, complete with its T_RFC spacing, run within a few dozen cycles. The small pending limit lets a withheld grant fill the backlog and trip the overflow flag within about forty cycles, after which the bench watches the backlog drain one sequence per request. Intervals of 10 to 40 cycles keep each scenario short, and they still leave room between requests for the per-cycle reference model to follow every pin.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  typedef enum logic [1:0] {
    CMD_INHIBIT  = 2'd0,
    CMD_NOP      = 2'd1,
    CMD_PRE_ALL  = 2'd2,
    CMD_AUTO_REF = 2'd3
  } sdramCmd_e;

  typedef struct packed {
    logic      takeGrant;
    logic      loadRp;
    logic      loadRfc;
    logic      countRef;
    sdramCmd_e cmd;
  } ctrlStrobe_t;

endpackage

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busGrant,
  input  logic        pendingAny,
  input  logic        waitDone,
  input  logic        lastRefresh,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        busReq
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_PRE, ST_RP_WAIT, ST_REF, ST_RFC_WAIT
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '{takeGrant: 1'b0, loadRp: 1'b0, loadRfc: 1'b0,
                  countRef: 1'b0, cmd: CMD_INHIBIT};
    unique case (state)
      ST_IDLE: begin
        if (pendingAny) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (busGrant) begin
          strobe.takeGrant = 1'b1;
          stateNext        = ST_PRE;
        end
      end
      ST_PRE: begin
        strobe.cmd    = CMD_PRE_ALL;
        strobe.loadRp = 1'b1;
        stateNext     = ST_RP_WAIT;
      end
      ST_RP_WAIT: begin
        strobe.cmd = CMD_NOP;
        if (waitDone) stateNext = ST_REF;
      end
      ST_REF: begin
        strobe.cmd      = CMD_AUTO_REF;
        strobe.loadRfc  = 1'b1;
        strobe.countRef = 1'b1;
        stateNext       = ST_RFC_WAIT;
      end
      ST_RFC_WAIT: begin
        strobe.cmd = CMD_NOP;
        if (waitDone) stateNext = lastRefresh ? ST_IDLE : ST_REF;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign busReq = busy;

endmodule

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int IVL_W       = 11,
  parameter int LEN_W       = 13,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 10,
  parameter int MAX_PENDING = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IVL_W-1:0]  refreshInterval,
  input  logic              burstMode,
  input  logic [LEN_W-1:0]  burstLen,
  input  ctrlStrobe_t       strobe,
  output logic              pendingAny,
  output logic              waitDone,
  output logic              lastRefresh,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              a10,
  output logic              overflow
);

  localparam int PEND_W   = $clog2(MAX_PENDING + 1);
  localparam int WAIT_MAX = (T_RP > T_RFC) ? T_RP : T_RFC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam logic [PEND_W-1:0] PEND_FULL = PEND_W'(MAX_PENDING);
  localparam logic [WAIT_W-1:0] RP_LOAD   = WAIT_W'(T_RP - 2);
  localparam logic [WAIT_W-1:0] RFC_LOAD  = WAIT_W'(T_RFC - 2);

  logic [IVL_W-1:0]  intervalCnt;
  logic              tick;
  logic [PEND_W-1:0] pendingCnt;
  logic [WAIT_W-1:0] waitCnt;
  logic [LEN_W-1:0]  refsLeft;
  logic [LEN_W-1:0]  refsLoad;

  // interval counter: restart at or past the programmed limit
  assign tick = (refreshInterval != '0) &&
                (intervalCnt >= (refreshInterval - IVL_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  intervalCnt <= '0;
    else if (refreshInterval == '0 || tick)     intervalCnt <= '0;
    else                                        intervalCnt <= intervalCnt + IVL_W'(1);
  end

  // pending request count with sticky loss flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendingCnt <= '0;
      overflow   <= 1'b0;
    end else if (tick && !strobe.takeGrant) begin
      if (pendingCnt == PEND_FULL) overflow   <= 1'b1;
      else                         pendingCnt <= pendingCnt + PEND_W'(1);
    end else if (!tick && strobe.takeGrant) begin
      pendingCnt <= pendingCnt - PEND_W'(1);
    end
  end

  assign pendingAny = (pendingCnt != '0);

  // recovery timer shared by tRP and tRFC waits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 waitCnt <= '0;
    else if (strobe.loadRp)    waitCnt <= RP_LOAD;
    else if (strobe.loadRfc)   waitCnt <= RFC_LOAD;
    else if (waitCnt != '0)    waitCnt <= waitCnt - WAIT_W'(1);
  end

  assign waitDone = (waitCnt == '0);

  // refreshes left in the current sequence, captured at grant
  assign refsLoad = !burstMode        ? LEN_W'(1) :
                    (burstLen == '0)  ? LEN_W'(1) : burstLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    refsLeft <= '0;
    else if (strobe.takeGrant)                    refsLeft <= refsLoad;
    else if (strobe.countRef && refsLeft != '0)   refsLeft <= refsLeft - LEN_W'(1);
  end

  assign lastRefresh = (refsLeft == '0);

  // command pin decode
  always_comb begin
    unique case (strobe.cmd)
      CMD_NOP:      {csN, rasN, casN, weN, a10} = 5'b0111_0;
      CMD_PRE_ALL:  {csN, rasN, casN, weN, a10} = 5'b0010_1;
      CMD_AUTO_REF: {csN, rasN, casN, weN, a10} = 5'b0001_0;
      default:      {csN, rasN, casN, weN, a10} = 5'b1111_0;
    endcase
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int IVL_W       = 11,
  parameter int LEN_W       = 13,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 10,
  parameter int MAX_PENDING = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [IVL_W-1:0]  refreshInterval,
  input  logic              burstMode,
  input  logic [LEN_W-1:0]  burstLen,
  input  logic              busGrant,
  output logic              busReq,
  output logic              busy,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              a10,
  output logic              overflow
);

  ctrlStrobe_t strobe;
  logic        pendingAny;
  logic        waitDone;
  logic        lastRefresh;

  refresh_sched_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busGrant    (busGrant),
    .pendingAny  (pendingAny),
    .waitDone    (waitDone),
    .lastRefresh (lastRefresh),
    .strobe      (strobe),
    .busy        (busy),
    .busReq      (busReq)
  );

  refresh_sched_dp #(
    .IVL_W       (IVL_W),
    .LEN_W       (LEN_W),
    .T_RP        (T_RP),
    .T_RFC       (T_RFC),
    .MAX_PENDING (MAX_PENDING)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .refreshInterval (refreshInterval),
    .burstMode       (burstMode),
    .burstLen        (burstLen),
    .strobe          (strobe),
    .pendingAny      (pendingAny),
    .waitDone        (waitDone),
    .lastRefresh     (lastRefresh),
    .csN             (csN),
    .rasN            (rasN),
    .casN            (casN),
    .weN             (weN),
    .a10             (a10),
    .overflow        (overflow)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int T_RP  = 3,
  parameter int T_RFC = 10
) (
  input logic clk,
  input logic rstN,
  input logic busGrant,
  input logic busReq,
  input logic busy,
  input logic csN,
  input logic rasN,
  input logic casN,
  input logic weN,
  input logic a10,
  input logic overflow
);

  localparam logic [31:0] SAT = 32'hFFFF;

  logic isPre, isRef, isNop;
  logic [31:0] sincePre, sinceRef;
  logic lastWasPre, refSeen;

  assign isPre = !csN && !rasN &&  casN && !weN;
  assign isRef = !csN && !rasN && !casN &&  weN;
  assign isNop = !csN &&  rasN &&  casN &&  weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sincePre   <= SAT;
      sinceRef   <= SAT;
      lastWasPre <= 1'b0;
      refSeen    <= 1'b0;
    end else begin
      sincePre <= isPre ? 32'd1 : ((sincePre < SAT) ? sincePre + 32'd1 : SAT);
      sinceRef <= isRef ? 32'd1 : ((sinceRef < SAT) ? sinceRef + 32'd1 : SAT);
      if (isPre)      lastWasPre <= 1'b1;
      else if (isRef) lastWasPre <= 1'b0;
      if (isRef)      refSeen    <= 1'b1;
    end
  end

  AST_PRE_A10: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> a10); // R4

  AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    isRef |-> (lastWasPre ? (sincePre >= T_RP) : (sinceRef >= T_RFC))); // R5

  AST_RFC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !isNop && !isRef && refSeen) |-> (sinceRef >= T_RFC)); // R6

  AST_CMD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy); // R3

  AST_PRE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> ($past(busGrant) && $past(busReq))); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow); // R10

endmodule

bind refresh_sched refresh_sched_chk #(
  .T_RP  (T_RP),
  .T_RFC (T_RFC)
) u_refresh_sched_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busGrant (busGrant),
  .busReq   (busReq),
  .busy     (busy),
  .csN      (csN),
  .rasN     (rasN),
  .casN     (casN),
  .weN      (weN),
  .a10      (a10),
  .overflow (overflow)
);

// File: tb/refresh_sched_bench.sv
module refresh_sched_bench;

  localparam int T_RP        = 3;
  localparam int T_RFC       = 5;
  localparam int MAX_PENDING = 3;
  localparam int IVL_W       = 8;
  localparam int LEN_W       = 3;

  localparam logic [4:0] P_PRE = 5'b0010_1;
  localparam logic [4:0] P_REF = 5'b0001_0;
  localparam logic [4:0] P_NOP = 5'b0111_0;
  localparam logic [4:0] P_INH = 5'b1111_0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [IVL_W-1:0] refreshInterval = '0;
  logic burstMode = 1'b0;
  logic [LEN_W-1:0] burstLen = '0;
  logic busGrant = 1'b0;
  logic busReq, busy, csN, rasN, casN, weN, a10, overflow;

  always #2 clk = ~clk;

  refresh_sched #(
    .IVL_W(IVL_W), .LEN_W(LEN_W), .T_RP(T_RP), .T_RFC(T_RFC),
    .MAX_PENDING(MAX_PENDING)
  ) u_refresh_sched (
    .clk(clk), .rstN(rstN), .refreshInterval(refreshInterval),
    .burstMode(burstMode), .burstLen(burstLen), .busGrant(busGrant),
    .busReq(busReq), .busy(busy), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .a10(a10), .overflow(overflow)
  );

  int checks = 0;
  int failures = 0;
  int obsPre = 0;
  int obsRef = 0;
  bit grantEn = 1'b0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model: pending count plus a queue of expected pins
  int ivCnt = 0;
  int pending = 0;
  bit mOvf = 1'b0;
  bit waitG = 1'b0;
  logic [4:0] q[$];

  always @(posedge clk) begin
    if (!rstN) begin
      ivCnt = 0; pending = 0; mOvf = 1'b0; waitG = 1'b0; q.delete();
    end else begin
      bit tick;
      bit dec;
      tick = (refreshInterval != 0) && (ivCnt >= int'(refreshInterval) - 1);
      if (refreshInterval == 0 || tick) ivCnt = 0; else ivCnt++;
      dec = 1'b0;
      if (q.size() > 0) begin
        void'(q.pop_front());
      end else if (waitG) begin
        if (busGrant) begin
          int n;
          n = burstMode ? ((burstLen == 0) ? 1 : int'(burstLen)) : 1;
          q.push_back(P_PRE);
          for (int i = 0; i < T_RP - 1; i++) q.push_back(P_NOP);
          for (int r = 0; r < n; r++) begin
            q.push_back(P_REF);
            for (int i = 0; i < T_RFC - 1; i++) q.push_back(P_NOP);
          end
          dec = 1'b1;
          waitG = 1'b0;
        end
      end else if (pending > 0) begin
        waitG = 1'b1;
      end
      if (tick && !dec) begin
        if (pending == MAX_PENDING) mOvf = 1'b1; else pending++;
      end else if (!tick && dec) begin
        pending--;
      end
    end
  end

  // per-cycle comparison, observation counters and grant policy
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [4:0] expPins;
      logic expBusy;
      string tag;
      if (q.size() > 0) begin expPins = q[0]; expBusy = 1'b1; end
      else begin expPins = P_INH; expBusy = waitG; end
      tag = (expPins == P_PRE) ? "R4" : (expPins == P_REF) ? "R5" :
            (expPins == P_NOP) ? "R6" : "R3";
      chk(tag, {csN, rasN, casN, weN, a10}, expPins);
      chk("R3", {busy, busReq}, {expBusy, expBusy});
      chk("R10", overflow, mOvf);
      if ({csN, rasN, casN, weN, a10} == P_PRE) obsPre++;
      if ({csN, rasN, casN, weN, a10} == P_REF) obsRef++;
    end
    busGrant <= grantEn && busReq;
  end

  task automatic step(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int basePre, baseRef;
    step(3);
    // R1: reset state
    chk("R1", {csN, rasN, casN, weN, a10}, P_INH);
    chk("R1", {busy, busReq, overflow}, 3'b000);
    rstN = 1'b1;
    step(1);
    chk("R1", {busy, busReq, overflow}, 3'b000);

    // R2: interval 0 raises no request
    step(30);
    chk("R2", busReq, 1'b0);
    chk("R2", obsPre, 0);

    // R2 R7: distributed mode, interval 20 for 120 cycles
    grantEn = 1'b1;
    basePre = obsPre; baseRef = obsRef;
    refreshInterval = 8'd20;
    step(120);
    refreshInterval = 8'd0;
    step(40);
    chk("R2", obsPre - basePre, 6);
    chk("R7", obsRef - baseRef, 6);

    // R8: burst of three per request
    basePre = obsPre; baseRef = obsRef;
    burstMode = 1'b1; burstLen = 3'd3; refreshInterval = 8'd40;
    step(80);
    refreshInterval = 8'd0;
    step(60);
    chk("R8", obsPre - basePre, 2);
    chk("R8", obsRef - baseRef, 6);

    // R8: burst length 0 gives one refresh
    basePre = obsPre; baseRef = obsRef;
    burstLen = 3'd0; refreshInterval = 8'd30;
    step(60);
    refreshInterval = 8'd0;
    step(40);
    chk("R8", obsRef - baseRef, 2);

    // R9 R10: withheld grant, backlog saturates then overflows
    burstMode = 1'b0;
    grantEn = 1'b0;
    refreshInterval = 8'd10;
    step(35);
    chk("R10", overflow, 1'b0);
    chk("R3", busReq, 1'b1);
    step(10);
    chk("R10", overflow, 1'b1);
    refreshInterval = 8'd0;
    basePre = obsPre; baseRef = obsRef;
    grantEn = 1'b1;
    step(60);
    chk("R9", obsPre - basePre, MAX_PENDING);
    chk("R9", obsRef - baseRef, MAX_PENDING);
    chk("R10", overflow, 1'b1);

    // R11: mode and length changed after grant do not alter the sequence
    basePre = obsPre; baseRef = obsRef;
    burstMode = 1'b1; burstLen = 3'd2; refreshInterval = 8'd15;
    for (int i = 0; i < 100 && obsPre == basePre; i++) step(1);
    burstMode = 1'b0; burstLen = 3'd7; refreshInterval = 8'd0;
    step(40);
    chk("R11", obsPre - basePre, 1);
    chk("R11", obsRef - baseRef, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule